// File: doc/BRIEF.md
# Triangle Vertex Classifier

This block prepares a filled-triangle drawer that has two line generators. It takes the three vertex positions of a triangle and finds their drawing order. For each line the generators must trace, it gives a start vertex, an end vertex and a step sign on each axis. It also flags the case where all three vertices coincide, so that the drawer plots one pixel and starts no generator. The block does no pixel writes and no error-term arithmetic.

The vertices are sorted from the smallest Y to the largest. One generator walks the long edge from the first vertex to the last. The other generator walks the upper edge from the first vertex to the middle one, and is then reused for the lower edge from the middle vertex to the last. The per-axis comparison flags of every vertex pair are also brought out, so the drawer can decide on other special cases from them. One registered stage holds all results, and a valid strobe marks them.

Top module: `tri_vertex_classifier`

## Requirements
- R1: While reset is asserted and after it is released, out_valid is 0 and every registered output is 0 until the first accepted input.
- R2: out_valid is high in exactly the cycle after a cycle with in_valid high. When in_valid is low, every result output keeps its value in the next cycle.
- R3: Flag bit p of each axis compares vertex pair p, where bit 0 = (v0,v1), bit 1 = (v0,v2) and bit 2 = (v1,v2). The gt flag means the coordinate of the lower-numbered vertex is larger, lt means it is smaller and eq means the two are equal. Exactly one of the three flags is set per pair and axis.
- R4: ord_top, ord_mid and ord_bot hold a permutation of the vertex numbers 0..2. The order is ascending Y, then ascending X when Y is equal, then ascending vertex number when both are equal.
- R5: single_point is 1 exactly when all three vertices have equal X and equal Y. In that case the active bit of all three line records is 0.
- R6: A line record has src in bits [1:0], dst in [3:2], the X step sign in bit 4, the Y step sign in bit 5 and active in bit 6. line_long runs from ord_top to ord_bot. Its active bit is 1 unless single_point is set.
- R7: line_upper runs from ord_top to ord_mid and line_lower runs from ord_mid to ord_bot. Each is active only when its two end vertices are at different positions.
- R8: A step sign bit is 1 (decrement) exactly when the end coordinate is smaller than the start coordinate, and 0 (increment) when it is greater or equal. Because of the sort, every Y step sign is 0.
- R9: All coordinates are two's-complement signed. A negative coordinate compares below zero and below every positive coordinate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Vertex set on the inputs is to be classified |
| vx0 | input | 16 | X of vertex 0, signed |
| vx1 | input | 16 | X of vertex 1, signed |
| vx2 | input | 16 | X of vertex 2, signed |
| vy0 | input | 16 | Y of vertex 0, signed |
| vy1 | input | 16 | Y of vertex 1, signed |
| vy2 | input | 16 | Y of vertex 2, signed |
| out_valid | output | 1 | Results are new this cycle |
| x_eq | output | 3 | X equal flags per pair |
| x_gt | output | 3 | X greater flags per pair |
| x_lt | output | 3 | X less flags per pair |
| y_eq | output | 3 | Y equal flags per pair |
| y_gt | output | 3 | Y greater flags per pair |
| y_lt | output | 3 | Y less flags per pair |
| ord_top | output | 2 | Vertex drawn first |
| ord_mid | output | 2 | Middle vertex |
| ord_bot | output | 2 | Vertex drawn last |
| single_point | output | 1 | All vertices coincide |
| line_long | output | 7 | Record for the first generator |
| line_upper | output | 7 | First record for the second generator |
| line_lower | output | 7 | Second record for the second generator |

## Verification
The directed patterns are chosen to tell apart the parts of the sort key. They include a general triangle, triangles whose Y ties must be settled by X, and fully coincident vertex pairs that can only be ordered by vertex number. These cases show whether each tie-break is applied and whether the matching short edge is switched off. An all-equal set separates the single-point path from the merely degenerate cases. Negative and extreme values (-32768, 32767) show whether comparisons are signed, and mirrored X layouts show each X step sign in both directions. A long additive sequence follows. Some of its vectors are forced into a small value range so that ties happen often, and the vectors are sent back to back and with idle gaps, to test the strobe and the hold behaviour.

// File: rtl/tvc_pkg.sv
package tvc_pkg;
  localparam int NV = 3;   // vertices
  localparam int NP = 3;   // vertex pairs

  typedef logic [1:0] vidx_t;

  // Line record; packing order gives the bit positions stated in R6.
  typedef struct packed {
    logic  act;
    logic  yneg;
    logic  xneg;
    vidx_t dst;
    vidx_t src;
  } line_rec_t;

  localparam int LREC_W = $bits(line_rec_t);

  // Pair p -> its lower and higher vertex number.
  function automatic int pair_lo(int p);
    return (p == 2) ? 1 : 0;
  endfunction

  function automatic int pair_hi(int p);
    return (p == 0) ? 1 : 2;
  endfunction

  // Two distinct vertex numbers -> pair index.
  function automatic int pair_of(int a, int b);
    case (a + b)
      1:       return 0;
      2:       return 1;
      default: return 2;
    endcase
  endfunction

  // Sign bit of a step: decrement when the end lies below the start.
  function automatic logic step_down(logic signed [31:0] from_c, logic signed [31:0] to_c);
    return to_c < from_c;
  endfunction
endpackage

// File: rtl/tvc_compare.sv
module tvc_compare
  import tvc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic signed [W-1:0] c [NV],
  output logic [NP-1:0]       eq,
  output logic [NP-1:0]       gt,
  output logic [NP-1:0]       lt
);
  for (genvar p = 0; p < NP; p++) begin : g_pair
    localparam int LO = pair_lo(p);
    localparam int HI = pair_hi(p);
    assign eq[p] = (c[LO] == c[HI]);
    assign gt[p] = (c[LO] >  c[HI]);
    assign lt[p] = (c[LO] <  c[HI]);
  end
endmodule

// File: rtl/tvc_order.sv
module tvc_order
  import tvc_pkg::*;
(
  input  logic [NP-1:0] x_eq,
  input  logic [NP-1:0] x_lt,
  input  logic [NP-1:0] y_eq,
  input  logic [NP-1:0] y_lt,
  output logic [NP-1:0] lo_first,
  output vidx_t         ord [NV]
);
  logic [1:0] rank [NV];

  // Lower-numbered vertex of each pair comes first on Y, then X, then number.
  for (genvar p = 0; p < NP; p++) begin : g_first
    assign lo_first[p] = y_lt[p] | (y_eq[p] & (x_lt[p] | x_eq[p]));
  end

  always_comb begin
    for (int i = 0; i < NV; i++) begin
      rank[i] = 2'd0;
      for (int j = 0; j < NV; j++) begin
        if (j != i) begin
          if ((j < i) ? lo_first[pair_of(i, j)] : !lo_first[pair_of(i, j)])
            rank[i] = rank[i] + 2'd1;
        end
      end
    end
  end

  always_comb begin
    for (int r = 0; r < NV; r++) begin
      ord[r] = '0;
      for (int i = 0; i < NV; i++) begin
        if (rank[i] == 2'(r)) ord[r] = vidx_t'(i);
      end
    end
  end
endmodule

// File: rtl/tvc_assign.sv
module tvc_assign
  import tvc_pkg::*;
#(
  parameter int W = 16
) (
  input  vidx_t               ord [NV],
  input  logic signed [W-1:0] xs  [NV],
  input  logic signed [W-1:0] ys  [NV],
  input  logic [NP-1:0]       x_eq,
  input  logic [NP-1:0]       y_eq,
  output logic                single_pt,
  output line_rec_t           recs [NP]
);
  logic [NP-1:0] pair_same;

  assign pair_same = x_eq & y_eq;
  assign single_pt = &pair_same;

  // Rank pair p gives one edge: 0 = upper, 1 = long, 2 = lower.
  for (genvar p = 0; p < NP; p++) begin : g_edge
    localparam int RS = pair_lo(p);
    localparam int RD = pair_hi(p);
    vidx_t s;
    vidx_t d;
    assign s = ord[RS];
    assign d = ord[RD];
    always_comb begin
      recs[p].src  = s;
      recs[p].dst  = d;
      recs[p].xneg = step_down(32'(xs[s]), 32'(xs[d]));
      recs[p].yneg = step_down(32'(ys[s]), 32'(ys[d]));
      recs[p].act  = !pair_same[pair_of(int'(s), int'(d))];
    end
  end
endmodule

// File: rtl/tri_vertex_classifier.sv
module tri_vertex_classifier
  import tvc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [W-1:0]  vx0,
  input  logic signed [W-1:0]  vx1,
  input  logic signed [W-1:0]  vx2,
  input  logic signed [W-1:0]  vy0,
  input  logic signed [W-1:0]  vy1,
  input  logic signed [W-1:0]  vy2,
  output logic                 out_valid,
  output logic [2:0]           x_eq,
  output logic [2:0]           x_gt,
  output logic [2:0]           x_lt,
  output logic [2:0]           y_eq,
  output logic [2:0]           y_gt,
  output logic [2:0]           y_lt,
  output logic [1:0]           ord_top,
  output logic [1:0]           ord_mid,
  output logic [1:0]           ord_bot,
  output logic                 single_point,
  output logic [6:0]           line_long,
  output logic [6:0]           line_upper,
  output logic [6:0]           line_lower
);
  logic signed [W-1:0] xs [NV];
  logic signed [W-1:0] ys [NV];
  logic [NP-1:0] cx_eq, cx_gt, cx_lt, cy_eq, cy_gt, cy_lt;
  logic [NP-1:0] lo_first;
  vidx_t         ord_n [NV];
  logic          single_n;
  line_rec_t     recs [NP];

  assign xs[0] = vx0;  assign xs[1] = vx1;  assign xs[2] = vx2;
  assign ys[0] = vy0;  assign ys[1] = vy1;  assign ys[2] = vy2;

  tvc_compare #(.W(W)) u_cmp_x (.c(xs), .eq(cx_eq), .gt(cx_gt), .lt(cx_lt));
  tvc_compare #(.W(W)) u_cmp_y (.c(ys), .eq(cy_eq), .gt(cy_gt), .lt(cy_lt));

  tvc_order u_order (
    .x_eq(cx_eq), .x_lt(cx_lt), .y_eq(cy_eq), .y_lt(cy_lt),
    .lo_first(lo_first), .ord(ord_n)
  );

  tvc_assign #(.W(W)) u_assign (
    .ord(ord_n), .xs(xs), .ys(ys), .x_eq(cx_eq), .y_eq(cy_eq),
    .single_pt(single_n), .recs(recs)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      x_eq         <= '0;  x_gt <= '0;  x_lt <= '0;
      y_eq         <= '0;  y_gt <= '0;  y_lt <= '0;
      ord_top      <= '0;  ord_mid <= '0;  ord_bot <= '0;
      single_point <= 1'b0;
      line_long    <= '0;  line_upper <= '0;  line_lower <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        x_eq         <= cx_eq;  x_gt <= cx_gt;  x_lt <= cx_lt;
        y_eq         <= cy_eq;  y_gt <= cy_gt;  y_lt <= cy_lt;
        ord_top      <= ord_n[0];
        ord_mid      <= ord_n[1];
        ord_bot      <= ord_n[2];
        single_point <= single_n;
        line_upper   <= recs[0];
        line_long    <= recs[1];
        line_lower   <= recs[2];
      end
    end
  end
endmodule

// File: rtl/tvc_checker.sv
module tvc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       out_valid,
  input logic [2:0] x_eq,
  input logic [2:0] x_gt,
  input logic [2:0] x_lt,
  input logic [2:0] y_eq,
  input logic [2:0] y_gt,
  input logic [2:0] y_lt,
  input logic [1:0] ord_top,
  input logic [1:0] ord_mid,
  input logic [1:0] ord_bot,
  input logic       single_point,
  input logic [6:0] line_long,
  input logic [6:0] line_upper,
  input logic [6:0] line_lower
);
  AST_VALID_LAG: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R2
  AST_VALID_ONLY: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R2
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable({line_long, line_upper, line_lower, ord_top, ord_mid, ord_bot, single_point, x_eq, y_eq})); // R2
  AST_FLAG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) out_valid |->
    ($countones({x_eq[0], x_gt[0], x_lt[0]}) == 1 && $countones({x_eq[1], x_gt[1], x_lt[1]}) == 1 &&
     $countones({x_eq[2], x_gt[2], x_lt[2]}) == 1 && $countones({y_eq[0], y_gt[0], y_lt[0]}) == 1 &&
     $countones({y_eq[1], y_gt[1], y_lt[1]}) == 1 && $countones({y_eq[2], y_gt[2], y_lt[2]}) == 1)); // R3
  AST_ORDER_PERM: assert property (@(posedge clk) disable iff (!rst_n) out_valid |->
    (ord_top != ord_mid && ord_top != ord_bot && ord_mid != ord_bot &&
     ord_top != 2'd3 && ord_mid != 2'd3 && ord_bot != 2'd3)); // R4
  AST_POINT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && single_point) |-> !(line_long[6] | line_upper[6] | line_lower[6])); // R5
  AST_POINT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && single_point) |-> (&x_eq && &y_eq)); // R5
  AST_LONG_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !single_point) |-> line_long[6]); // R6
  AST_LONG_ENDS: assert property (@(posedge clk) disable iff (!rst_n) out_valid |->
    (line_long[1:0] == ord_top && line_long[3:2] == ord_bot)); // R6
  AST_CHAIN: assert property (@(posedge clk) disable iff (!rst_n) out_valid |->
    (line_upper[1:0] == ord_top && line_upper[3:2] == line_lower[1:0] && line_lower[3:2] == ord_bot)); // R7
  AST_Y_ASCEND: assert property (@(posedge clk) disable iff (!rst_n) out_valid |->
    !(line_long[5] | line_upper[5] | line_lower[5])); // R8
endmodule

bind tri_vertex_classifier tvc_checker u_chk (.*);

// File: tb/sim_tri_vertex_classifier.sv
`timescale 1ns/1ps
module sim_tri_vertex_classifier;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [15:0] vx0 = '0, vx1 = '0, vx2 = '0, vy0 = '0, vy1 = '0, vy2 = '0;
  logic out_valid, single_point;
  logic [2:0] x_eq, x_gt, x_lt, y_eq, y_gt, y_lt;
  logic [1:0] ord_top, ord_mid, ord_bot;
  logic [6:0] line_long, line_upper, line_lower;

  always #2 clk = ~clk;

  tri_vertex_classifier u0 (.*);

  typedef struct packed {
    logic [2:0] xe, xg, xl, ye, yg, yl;
    logic [1:0] t, m, b;
    logic       sp;
    logic [6:0] ll, lu, lw;
  } exp_t;

  exp_t q[$];
  exp_t last;
  bit   have_last = 0;
  int   total = 0;
  int   bad = 0;
  bit   finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Line record per R6: {act, yneg, xneg, dst, src}; step signs per R8.
  function automatic logic [6:0] mk(input int s, input int d, input logic signed [15:0] x[3], input logic signed [15:0] y[3]);
    logic a;
    a = !(x[s] == x[d] && y[s] == y[d]);
    return {a, (y[d] < y[s]), (x[d] < x[s]), 2'(d), 2'(s)};
  endfunction

  function automatic exp_t model(input logic signed [15:0] x[3], input logic signed [15:0] y[3]);
    exp_t e;
    int pa[3] = '{0, 0, 1};
    int pb[3] = '{1, 2, 2};
    logic [33:0] k[3];
    int o[3] = '{0, 1, 2};
    for (int p = 0; p < 3; p++) begin
      e.xe[p] = x[pa[p]] == x[pb[p]];
      e.xg[p] = x[pa[p]] >  x[pb[p]];
      e.xl[p] = x[pa[p]] <  x[pb[p]];
      e.ye[p] = y[pa[p]] == y[pb[p]];
      e.yg[p] = y[pa[p]] >  y[pb[p]];
      e.yl[p] = y[pa[p]] <  y[pb[p]];
    end
    // sort key: offset-binary Y, then X, then vertex number
    for (int i = 0; i < 3; i++) k[i] = {y[i] ^ 16'h8000, x[i] ^ 16'h8000, 2'(i)};
    for (int pass = 0; pass < 2; pass++)
      for (int i = 0; i < 2; i++)
        if (k[o[i]] > k[o[i+1]]) begin
          int t;
          t = o[i]; o[i] = o[i+1]; o[i+1] = t;
        end
    e.t = 2'(o[0]); e.m = 2'(o[1]); e.b = 2'(o[2]);
    e.sp = (x[0] == x[1] && x[1] == x[2] && y[0] == y[1] && y[1] == y[2]);
    e.ll = mk(o[0], o[2], x, y);
    e.lu = mk(o[0], o[1], x, y);
    e.lw = mk(o[1], o[2], x, y);
    return e;
  endfunction

  task automatic send(input logic signed [15:0] a0, a1, a2, b0, b1, b2);
    logic signed [15:0] x[3];
    logic signed [15:0] y[3];
    x = '{a0, a1, a2};
    y = '{b0, b1, b2};
    @(negedge clk);
    vx0 = a0; vx1 = a1; vx2 = a2; vy0 = b0; vy1 = b1; vy2 = b2;
    in_valid = 1'b1;
    q.push_back(model(x, y));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic compare(input exp_t e, input string ctx);
    chk({x_eq, x_gt, x_lt, y_eq, y_gt, y_lt} == {e.xe, e.xg, e.xl, e.ye, e.yg, e.yl},
        {"R3 R9 flags ", ctx}, 64'({x_eq, x_gt, x_lt, y_eq, y_gt, y_lt}), 64'({e.xe, e.xg, e.xl, e.ye, e.yg, e.yl}));
    chk({ord_top, ord_mid, ord_bot} == {e.t, e.m, e.b}, {"R4 order ", ctx},
        64'({ord_top, ord_mid, ord_bot}), 64'({e.t, e.m, e.b}));
    chk(single_point == e.sp, {"R5 single_point ", ctx}, 64'(single_point), 64'(e.sp));
    chk(line_long == e.ll, {"R6 R8 line_long ", ctx}, 64'(line_long), 64'(e.ll));
    chk({line_upper, line_lower} == {e.lu, e.lw}, {"R7 R8 short lines ", ctx},
        64'({line_upper, line_lower}), 64'({e.lu, e.lw}));
  endtask

  // Monitor: pops one expected item per strobe; otherwise checks hold (R2).
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (out_valid) begin
        if (q.size() == 0) begin
          chk(1'b0, "R2 strobe without input", 64'(1), 64'(0));
        end else begin
          exp_t e;
          e = q.pop_front();
          compare(e, "result");
          last = e;
          have_last = 1;
        end
      end else if (have_last) begin
        compare(last, "R2 hold");
      end
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] ax, bx, cx, ay, by, cy, sel;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid in reset", 64'(out_valid), 0);
    chk({line_long, line_upper, line_lower, single_point, ord_top, ord_mid, ord_bot} == '0,
        "R1 outputs in reset", 64'({line_long, line_upper, line_lower}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && line_long == '0 && x_eq == '0, "R1 after release",
        64'({out_valid, line_long}), 0);

    // general triangle
    send(10, 40, 25, 5, 20, 60); idle(2);
    // R5 all vertices equal
    send(7, 7, 7, -3, -3, -3); idle(2);
    // R4 Y tie settled by X; R8 X step both directions
    send(30, 10, 20, 8, 8, 50); idle(1);
    send(5, 50, 20, 40, 0, 40); idle(1);
    // R4 R7 coincident pair ordered by vertex number (top==mid, then mid==bot)
    send(3, 3, 9, 1, 1, 9);
    send(9, 2, 9, 9, 1, 9);
    send(4, 4, 4, 6, 2, 6); idle(2);
    // R9 signed extremes
    send(-32768, 32767, 0, 32767, -32768, -1); idle(1);
    send(-5, 5, -100, -1, 1, 0); idle(1);
    // vertical and horizontal collinear
    send(0, 0, 0, 30, 10, 20);
    send(-9, 9, 0, 4, 4, 4); idle(3);

    // additive sweep, some vectors squeezed to small range for ties
    ax = 16'd1; bx = 16'd900; cx = 16'hF000; ay = 16'd77; by = 16'h8001; cy = 16'd5;
    sel = 0;
    for (int n = 0; n < 400; n++) begin
      ax += 16'd1237; bx += 16'd4099; cx += 16'd7919;
      ay += 16'd2221; by += 16'd317;  cy += 16'd6007;
      sel += 16'd3;
      if (sel[1:0] == 2'd0)
        send(16'(ax[1:0]), 16'(bx[1:0]), 16'(cx[1:0]), 16'(ay[1:0]), 16'(by[1:0]), 16'(cy[1:0]));
      else
        send(ax, bx, cx, ay, by, cy);
      if (n % 7 == 3) idle(2);
    end
    idle(4);
    chk(q.size() == 0, "R2 results outstanding", 64'(q.size()), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule